// File: doc/BRIEF.md
# SPI Read Address Word-Aligner

This block sits in series on the wires between an SPI host and a serial flash. The serial clock, chip select and the flash's return data pass straight through. The host-to-flash data line passes through a single two-way selector.

The block counts the bits of each transaction while chip select is low. Once the first eight bits have formed the plain read command (0x03), it drives the last two bits of the 16-bit address to zero on their way to the flash. A read that the host aims at any byte of a 4-byte word therefore starts at the first byte of that word. Every other command, and every other bit, reaches the flash as sent.

The selector is combinational. Its choice comes from registers that update on the rising SCK edge before the bit is sent, so no clock edges and no delay are added to the stream. The block runs on a system clock that is much faster than SCK. The host pins are taken to be in that clock's domain, and the block finds SCK edges by comparing SCK with its value one clock earlier. The interface uses SPI mode 0: the flash samples on the rising edge and the host changes data while SCK is low.

Top module: `spi_read_align_top`

## Requirements
- R1: The flash-side SCK and CS_n equal the host-side SCK and CS_n at all times, and the host-side MISO equals the flash-side MISO at all times.
- R2: In a transaction whose first eight MOSI bits, taken MSB first, equal 0x03, bits 22 and 23 of the transaction reach the flash as 0. Bits are counted from 0 at the first bit after CS_n falls, so these are address bits 1 and 0.
- R3: In a 0x03 transaction, every bit other than 22 and 23 reaches the flash unchanged. This covers the opcode, address bits 15 to 2, and every data-phase bit from bit 24 onward.
- R4: In a transaction whose opcode is not 0x03, every MOSI bit reaches the flash unchanged.
- R5: CS_n high ends the transaction and clears the bit position and the assembled opcode. A following transaction is judged only on its own first eight bits, even when the previous transaction was cut short.
- R6: The bit position advances by exactly one per rising SCK edge while CS_n is low. It stops at the end of the address phase, so a long data phase never wraps back into the masking window.
- R7: While reset is high, and afterwards while CS_n is high, the flash-side MOSI equals the host-side MOSI.
- R8: SCK edges that occur while CS_n is high do not advance the bit position.
- R9: An opcode that differs from 0x03 in any single bit (for example 0x02, 0x07 or 0x83) does not cause masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| host_sck | input | 1 | Serial clock from the host |
| host_cs_n | input | 1 | Active-low chip select from the host |
| host_mosi | input | 1 | Serial data from the host |
| host_miso | output | 1 | Serial data returned to the host |
| flash_sck | output | 1 | Serial clock forwarded to the flash |
| flash_cs_n | output | 1 | Chip select forwarded to the flash |
| flash_mosi | output | 1 | Serial data forwarded to the flash, with the read address aligned |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
The hardest cases to reach from the ports are those where the bit position and the opcode must not carry across a transaction boundary. One case is a read cut off part-way through the masking window, followed at once by a non-read or another read. The other is SCK toggling while chip select is high. The stimulus builds these cases directly: it ends transactions after 20 and 23 bits, inserts idle SCK pulses before a read, and uses opcodes one bit away from 0x03. It then mixes seeded random reads and non-reads with random addresses and data. For each transaction it compares the whole bit stream seen at the flash with a stream computed from the requirements.

// File: rtl/spi_read_align_pkg.sv
package spi_read_align_pkg;

    // Phase of the current transaction, derived from the bit position.
    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_ADDR   = 2'd1,
        PH_DATA   = 2'd2
    } xfer_phase_e;

    // Position record carried from the bit tracker to the other stages.
    typedef struct packed {
        logic        active;  // CS_n low
        logic        rise;    // rising SCK edge seen this clock
        xfer_phase_e phase;
    } xfer_pos_t;

    // Phase for a bit position, given the opcode and address lengths.
    function automatic xfer_phase_e phase_of(input int unsigned pos,
                                             input int unsigned opc_bits,
                                             input int unsigned addr_bits);
        if (pos < opc_bits)
            return PH_OPCODE;
        else if (pos < opc_bits + addr_bits)
            return PH_ADDR;
        else
            return PH_DATA;
    endfunction

    // True when the position lies in the low address bits that are forced to zero.
    function automatic logic in_clear_window(input int unsigned pos,
                                             input int unsigned opc_bits,
                                             input int unsigned addr_bits,
                                             input int unsigned clr_bits);
        return (clr_bits != 0) &&
               (pos >= opc_bits + addr_bits - clr_bits) &&
               (pos <  opc_bits + addr_bits);
    endfunction

endpackage

// File: rtl/spi_read_align_edge.sv
module spi_read_align_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic active
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst)
            sck_q <= 1'b0;
        else
            sck_q <= sck;
    end

    // A rising edge counts only while the device is selected.
    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign active   = ~cs_n;
endmodule

// File: rtl/spi_read_align_bitpos.sv
module spi_read_align_bitpos
    import spi_read_align_pkg::*;
#(
    parameter int unsigned OPC_BITS  = 8,
    parameter int unsigned ADDR_BITS = 16,
    parameter int unsigned CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck_rise,
    output logic [CNT_W-1:0] bit_cnt,
    output xfer_pos_t        pos
);
    localparam int unsigned LIMIT = OPC_BITS + ADDR_BITS;
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || cs_n)
            bit_cnt <= '0;
        else if (sck_rise && bit_cnt != LIMIT_C)
            bit_cnt <= bit_cnt + 1'b1;
    end

    always_comb begin
        pos.active = ~cs_n;
        pos.rise   = sck_rise;
        pos.phase  = phase_of(int'(bit_cnt), OPC_BITS, ADDR_BITS);
    end
endmodule

// File: rtl/spi_read_align_opdec.sv
module spi_read_align_opdec
    import spi_read_align_pkg::*;
#(
    parameter int unsigned         OPC_BITS = 8,
    parameter logic [OPC_BITS-1:0] READ_OPC = 8'h03
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      mosi_raw,
    input  xfer_pos_t pos,
    output logic      is_read
);
    logic [OPC_BITS-1:0] opc_sr;

    // The opcode is gathered from the host's unaltered line, MSB first.
    always_ff @(posedge clk) begin
        if (rst || cs_n)
            opc_sr <= '0;
        else if (pos.rise && pos.phase == PH_OPCODE)
            opc_sr <= {opc_sr[OPC_BITS-2:0], mosi_raw};
    end

    assign is_read = pos.active && (pos.phase != PH_OPCODE) && (opc_sr == READ_OPC);
endmodule

// File: rtl/spi_read_align_mux.sv
module spi_read_align_mux
    import spi_read_align_pkg::*;
#(
    parameter int unsigned OPC_BITS  = 8,
    parameter int unsigned ADDR_BITS = 16,
    parameter int unsigned CLR_BITS  = 2,
    parameter int unsigned CNT_W     = 5
) (
    input  logic             mosi_in,
    input  logic             is_read,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             mosi_out
);
    logic force_zero;

    generate
        if (CLR_BITS == 0) begin : g_no_clear
            assign force_zero = 1'b0;
        end else begin : g_clear
            assign force_zero = is_read &&
                in_clear_window(int'(bit_cnt), OPC_BITS, ADDR_BITS, CLR_BITS);
        end
    endgenerate

    assign mosi_out = force_zero ? 1'b0 : mosi_in;
endmodule

// File: rtl/spi_read_align_top.sv
module spi_read_align_top
    import spi_read_align_pkg::*;
#(
    parameter int unsigned         OPC_BITS  = 8,
    parameter int unsigned         ADDR_BITS = 16,
    parameter int unsigned         CLR_BITS  = 2,
    parameter logic [OPC_BITS-1:0] READ_OPC  = 8'h03
) (
    input  logic clk,
    input  logic rst,
    input  logic host_sck,
    input  logic host_cs_n,
    input  logic host_mosi,
    output logic host_miso,
    output logic flash_sck,
    output logic flash_cs_n,
    output logic flash_mosi,
    input  logic flash_miso
);
    localparam int unsigned CNT_W = $clog2(OPC_BITS + ADDR_BITS + 1);

    logic             sck_rise;
    logic             active;
    logic [CNT_W-1:0] bit_cnt;
    xfer_pos_t        pos;
    logic             is_read;

    assign flash_sck  = host_sck;
    assign flash_cs_n = host_cs_n;
    assign host_miso  = flash_miso;

    spi_read_align_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .sck      (host_sck),
        .cs_n     (host_cs_n),
        .sck_rise (sck_rise),
        .active   (active)
    );

    spi_read_align_bitpos #(
        .OPC_BITS  (OPC_BITS),
        .ADDR_BITS (ADDR_BITS),
        .CNT_W     (CNT_W)
    ) bitpos_i (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (~active),
        .sck_rise (sck_rise),
        .bit_cnt  (bit_cnt),
        .pos      (pos)
    );

    spi_read_align_opdec #(
        .OPC_BITS (OPC_BITS),
        .READ_OPC (READ_OPC)
    ) opdec_i (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (host_cs_n),
        .mosi_raw (host_mosi),
        .pos      (pos),
        .is_read  (is_read)
    );

    spi_read_align_mux #(
        .OPC_BITS  (OPC_BITS),
        .ADDR_BITS (ADDR_BITS),
        .CLR_BITS  (CLR_BITS),
        .CNT_W     (CNT_W)
    ) mux_i (
        .mosi_in  (host_mosi),
        .is_read  (is_read),
        .bit_cnt  (bit_cnt),
        .mosi_out (flash_mosi)
    );
endmodule

// File: rtl/spi_read_align_chk.sv
module spi_read_align_chk #(
    parameter int unsigned OPC_BITS  = 8,
    parameter int unsigned ADDR_BITS = 16,
    parameter int unsigned CLR_BITS  = 2,
    parameter int unsigned CNT_W     = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             host_cs_n,
    input logic             host_mosi,
    input logic             flash_mosi,
    input logic             sck_rise,
    input logic             is_read,
    input logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(OPC_BITS + ADDR_BITS);
    localparam logic [CNT_W-1:0] WLO_C   = CNT_W'(OPC_BITS + ADDR_BITS - CLR_BITS);
    localparam logic [CNT_W-1:0] OPC_C   = CNT_W'(OPC_BITS);

    // R2
    only_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flash_mosi != host_mosi) |-> (host_mosi && !host_cs_n && is_read));

    // R3
    outside_window_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt < WLO_C || bit_cnt == LIMIT_C) |-> (flash_mosi == host_mosi));

    // R4
    nonread_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt >= OPC_C && !is_read) |-> (flash_mosi == host_mosi));

    // R5
    cs_clear_chk: assert property (@(posedge clk) disable iff (rst)
        host_cs_n |=> (bit_cnt == '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LIMIT_C);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_cs_n && !sck_rise) |=> $stable(bit_cnt));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (bit_cnt == '0));
endmodule

bind spi_read_align_top spi_read_align_chk #(
    .OPC_BITS  (OPC_BITS),
    .ADDR_BITS (ADDR_BITS),
    .CLR_BITS  (CLR_BITS),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_cs_n  (host_cs_n),
    .host_mosi  (host_mosi),
    .flash_mosi (flash_mosi),
    .sck_rise   (sck_rise),
    .is_read    (is_read),
    .bit_cnt    (bit_cnt)
);

// File: tb/spi_read_align_tb.sv
module spi_read_align_top_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_sck = 1'b0, host_cs_n = 1'b1, host_mosi = 1'b0, flash_miso = 1'b0;
    logic host_miso, flash_sck, flash_cs_n, flash_mosi;
    int   total = 0;
    int   bad   = 0;

    always #10 clk = ~clk;

    spi_read_align_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_sck   (host_sck),
        .host_cs_n  (host_cs_n),
        .host_mosi  (host_mosi),
        .host_miso  (host_miso),
        .flash_sck  (flash_sck),
        .flash_cs_n (flash_cs_n),
        .flash_mosi (flash_mosi),
        .flash_miso (flash_miso)
    );

    task automatic check(input bit ok, input string req, input logic [55:0] act, input logic [55:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected flash-side stream: read opcode clears bits 22 and 23.
    function automatic logic [55:0] expect_stream(input logic [7:0] opc, input logic [55:0] tx, input int nbits);
        logic [55:0] e = '0;
        for (int k = 0; k < nbits; k++) begin
            e[55-k] = tx[55-k];
            if (opc == 8'h03 && (k == 22 || k == 23)) e[55-k] = 1'b0;
        end
        return e;
    endfunction

    task automatic run_frame(input logic [7:0] opc, input logic [15:0] adr, input logic [31:0] dat,
                             input int nbits, input string req);
        logic [55:0] tx;
        logic [55:0] got;
        bit pass_ok;
        tx = {opc, adr, dat};
        got = '0;
        pass_ok = 1'b1;
        @(negedge clk) host_cs_n = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            host_mosi  = tx[55-k];
            flash_miso = 1'($urandom);
            @(negedge clk);
            got[55-k] = flash_mosi;
            if (host_miso !== flash_miso || flash_sck !== host_sck || flash_cs_n !== host_cs_n)
                pass_ok = 1'b0;
            host_sck = 1'b1;
            @(negedge clk);
            if (flash_sck !== 1'b1 || host_miso !== flash_miso) pass_ok = 1'b0;
            @(negedge clk) host_sck = 1'b0;
        end
        @(negedge clk) host_cs_n = 1'b1;
        @(negedge clk);
        if (flash_cs_n !== 1'b1) pass_ok = 1'b0;
        @(negedge clk);
        check(got == expect_stream(opc, tx, nbits), req, got, expect_stream(opc, tx, nbits));
        check(pass_ok, "R1 passthrough", {55'd0, pass_ok}, 56'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] opc;
        void'($urandom(32'd20240611));
        // R7: pass-through during and after reset with CS_n high
        @(negedge clk) host_mosi = 1'b1;
        @(negedge clk);
        check(flash_mosi === 1'b1, "R7 in reset", {55'd0, flash_mosi}, 56'd1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        host_mosi = 1'b0;
        @(negedge clk);
        check(flash_mosi === 1'b0, "R7 after reset", {55'd0, flash_mosi}, 56'd0);
        host_mosi = 1'b1;
        @(negedge clk);
        check(flash_mosi === 1'b1, "R7 idle", {55'd0, flash_mosi}, 56'd1);

        // R2 R3: unaligned and aligned reads
        run_frame(8'h03, 16'h1001, 32'hDEADBEEF, 56, "R2 addr 1001");
        run_frame(8'h03, 16'h1002, 32'hFFFFFFFF, 56, "R2 addr 1002");
        run_frame(8'h03, 16'h1003, 32'hA5A5A5A5, 56, "R2 addr 1003");
        run_frame(8'h03, 16'h1000, 32'h12345678, 56, "R3 aligned");
        run_frame(8'h03, 16'hFFFF, 32'hFFFFFFFF, 56, "R3 data ones");

        // R9 R4: near-miss and other opcodes
        run_frame(8'h02, 16'hFFFF, 32'hFFFFFFFF, 56, "R9 opc 02");
        run_frame(8'h07, 16'h0003, 32'hFFFFFFFF, 56, "R9 opc 07");
        run_frame(8'h83, 16'h0003, 32'hFFFFFFFF, 56, "R9 opc 83");
        run_frame(8'h0B, 16'h7777, 32'h0F0F0F0F, 56, "R4 opc 0B");

        // R8: SCK toggles with CS_n high must not shift the window
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) host_sck = 1'b1;
            @(negedge clk) host_sck = 1'b0;
        end
        run_frame(8'h03, 16'h1237, 32'hFFFFFFFF, 56, "R8 idle sck then read");

        // R5: aborted reads followed by fresh transactions
        run_frame(8'h03, 16'hFFFF, 32'h0, 20, "R5 read cut at 20");
        run_frame(8'h9F, 16'hFFFF, 32'hFFFFFFFF, 56, "R5 non-read after cut");
        run_frame(8'h03, 16'hFFFF, 32'h0, 23, "R5 read cut at 23");
        run_frame(8'h03, 16'hABCD, 32'h55AA55AA, 56, "R5 read after cut");
        run_frame(8'h03, 16'hFFFF, 32'hFFFFFFFF, 56, "R6 long data phase");

        // Random mix of reads and other commands
        for (int n = 0; n < 40; n++) begin
            opc = ($urandom % 2 == 0) ? 8'h03 : 8'($urandom);
            run_frame(opc, 16'($urandom), $urandom, 56, (opc == 8'h03) ? "R2 R3 random read" : "R4 random cmd");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule